// File: doc/BRIEF.md
# Dual-Target Serial Register Access Bridge

This block is a serial peripheral master that lets a host read and write raw registers in two peripheral chips hanging off one serial bus: a data converter and a clock synthesizer. The host places a target number, a 16-bit register address and a 32-bit write word on its inputs. It then starts the access with a low-to-high change on either the write strobe or the read strobe. The bridge sends one 49-bit frame with the chip select of the chosen target held low. On a read, it shifts the returned word into a 32-bit result register. A level-sensitive idle flag tells the host when the next strobe may be issued.

All inputs and outputs belong to the single control clock domain. The serial clock is made by dividing that clock. The state machine has five states:
- `ST_IDLE`: waiting for a strobe.
- `ST_SETUP`: chip select low, first bit on the data line, for one half period.
- `ST_SHIFT`: serial clock toggling.
- `ST_HOLD`: chip select held for one half period after the last falling edge.
- `ST_DONE`: one cycle in which the read result is stored.

The named transitions are:
- accept (`ST_IDLE`→`ST_SETUP`, on a strobe edge with a valid target)
- lead (`ST_SETUP`→`ST_SHIFT`, on a divider tick)
- last_bit (`ST_SHIFT`→`ST_HOLD`, on the falling edge after bit 49)
- release (`ST_HOLD`→`ST_DONE`, on a tick)
- finish (`ST_DONE`→`ST_IDLE`, unconditional)

A strobe edge with an invalid target is a reject: the machine stays in `ST_IDLE` and only the status changes.

Top module: `spi_reg_bridge`

## Requirements
- R1: Target value 0 drives `cs_conv_n` low for the frame and value 1 drives `cs_pll_n` low; at no time are both chip selects low.
- R2: A frame is 49 bits, sent most significant bit first: one direction bit (1 = read, 0 = write), then the 16 address bits, then 32 data bits. The data bits are the write word on a write and all zeros on a read. `mosi` changes only after a falling `sclk` edge, so the peripheral samples it on the rising edge.
- R3: A write frame starts only on a low-to-high change of `wr_strobe`; keeping the strobe high after the frame starts no further frame.
- R4: A read frame starts only on a low-to-high change of `rd_strobe`. The 32 `miso` bits sampled on the rising `sclk` edges of the data phase, first bit most significant, become `rd_data`.
- R5: `idle` is high only when no frame is in progress. It goes low on the first clock edge after an accepted strobe edge and stays low until the frame ends. While `idle` is high, both chip selects are high and `sclk` is low.
- R6: A strobe edge with a target value other than 0 or 1 starts no frame, leaves `idle` high and sets `status` to 3. An accepted request sets `status` to 0.
- R7: Strobe edges that arrive while a frame is in progress are ignored. Target, address and write word are captured when the request is accepted, so changing them during the frame does not alter the frame.
- R8: `rd_data` is updated before `idle` returns high at the end of a read. It keeps its value through writes and rejected requests until the next read completes.
- R9: When both strobes rise in the same cycle, the request is a write.
- R10: After reset, `idle` is 1, both chip selects are 1, `sclk` is 0, `rd_data` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_sel | input | 8 | Target number: 0 converter, 1 clock synthesizer |
| reg_addr | input | 16 | Peripheral register address |
| wr_data | input | 32 | Word to write |
| wr_strobe | input | 1 | Rising edge starts a write |
| rd_strobe | input | 1 | Rising edge starts a read |
| rd_data | output | 32 | Last word read |
| idle | output | 1 | High when no frame is in progress |
| status | output | 8 | 0 accepted, 3 undefined target |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripherals |
| miso | input | 1 | Serial data from the peripherals |
| cs_conv_n | output | 1 | Converter chip select, active low |
| cs_pll_n | output | 1 | Clock synthesizer chip select, active low |

## Verification
The assertions assume that both strobes are low while reset is asserted and that a strobe edge is only judged against `tgt_sel` as it stands in that same cycle. The stimulus therefore keeps both strobes low through reset and changes all inputs on the falling clock edge. The assertions also assume that `miso` only matters on rising `sclk` edges. The bench's peripheral model updates `miso` only on falling `sclk` edges or when a chip select falls, so the value is never in flux when the bridge samples it.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_DONE
    } bridge_state_t;

    localparam logic [7:0] STAT_OK      = 8'd0;
    localparam logic [7:0] STAT_BAD_TGT = 8'd3;

    localparam logic [7:0] TGT_CONV = 8'd0;
    localparam logic [7:0] TGT_PLL  = 8'd1;

endpackage

// File: rtl/spi_strobe_rise.sv
module spi_strobe_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_edge
            assign rise[g] = level[g] & ~prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int FRAME_BITS = 49,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  rise_ev,
    input  logic                  fall_ev,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic [DATA_W-1:0]     rx_word,
    output logic [$clog2(FRAME_BITS+1)-1:0] bits_done
);
    localparam int BW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] tx_q;
    logic [DATA_W-1:0]     rx_q;
    logic [BW-1:0]         cnt_q;
    logic                  sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (load) begin
            tx_q   <= load_word;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (rise_ev) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[DATA_W-2:0], miso};
            cnt_q  <= cnt_q + 1'b1;
        end else if (fall_ev) begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = tx_q[FRAME_BITS-1];
    assign rx_word   = rx_q;
    assign bits_done = cnt_q;
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
    parameter int SEL_W    = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  tgt_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_strobe,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              idle,
    output logic [7:0]        status,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_conv_n,
    output logic              cs_pll_n
);
    import spi_bridge_pkg::*;

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int BW         = $clog2(FRAME_BITS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS);

    bridge_state_t state_q, state_d;

    logic [1:0]            rises;
    logic                  wr_rise, rd_rise;
    logic                  tick;
    logic                  tgt_ok, start, accept, is_read;
    logic                  rise_ev, fall_ev, run;
    logic [FRAME_BITS-1:0] frame_word;
    logic [DATA_W-1:0]     rx_word;
    logic [BW-1:0]         bits_done;
    logic                  req_rd_q;

    spi_strobe_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({rd_strobe, wr_strobe}),
        .rise  (rises)
    );
    assign wr_rise = rises[0];
    assign rd_rise = rises[1];

    assign tgt_ok  = (tgt_sel == SEL_W'(TGT_CONV)) || (tgt_sel == SEL_W'(TGT_PLL));
    assign start   = (state_q == ST_IDLE) && (wr_rise || rd_rise);
    assign accept  = start && tgt_ok;
    assign is_read = !wr_rise;

    assign frame_word = {is_read, reg_addr, (is_read ? {DATA_W{1'b0}} : wr_data)};

    assign run = (state_q == ST_SETUP) || (state_q == ST_SHIFT) || (state_q == ST_HOLD);

    spi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    assign rise_ev = (state_q == ST_SHIFT) && tick && !sclk;
    assign fall_ev = (state_q == ST_SHIFT) && tick && sclk;

    spi_shift_path #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (frame_word),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .bits_done (bits_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SETUP;
            ST_SETUP: if (tick)   state_d = ST_SHIFT;
            ST_SHIFT: if (fall_ev && bits_done == LAST_BIT) state_d = ST_HOLD;
            ST_HOLD:  if (tick)   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_conv_n <= 1'b1;
            cs_pll_n  <= 1'b1;
            status    <= STAT_OK;
            rd_data   <= '0;
            req_rd_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_rd_q  <= is_read;
                        cs_conv_n <= tgt_sel[0];
                        cs_pll_n  <= ~tgt_sel[0];
                        status    <= STAT_OK;
                    end else if (start) begin
                        status    <= STAT_BAD_TGT;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_conv_n <= 1'b1;
                        cs_pll_n  <= 1'b1;
                    end
                end
                ST_DONE: begin
                    if (req_rd_q) rd_data <= rx_word;
                end
                default: ;
            endcase
        end
    end

    assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk #(
    parameter int SEL_W    = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  tgt_sel,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_strobe,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rd_data,
    input logic              idle,
    input logic [7:0]        status,
    input logic              sclk,
    input logic              mosi,
    input logic              miso,
    input logic              cs_conv_n,
    input logic              cs_pll_n
);
    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_conv_n || cs_pll_n)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (cs_conv_n && cs_pll_n && !sclk)); // R5

    AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_conv_n || !cs_pll_n) |-> !idle); // R5

    AST_TARGET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_conv_n |=> cs_pll_n); // R7

    AST_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (tgt_sel > SEL_W'(1)) && ($rose(wr_strobe) || $rose(rd_strobe)))
        |=> (idle && status == 8'd3)); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(rd_data)); // R8

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi)); // R2
endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_DIV(HALF_DIV)
) u_chk (.*);

// File: tb/spi_reg_bridge_tb.sv
module spi_reg_bridge_tb;
    localparam int NV = 6;
    localparam int VW = 1 + 8 + 16 + 32 + 32;

    // {is_read, target, address, write word, peripheral reply}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 8'd0, 16'h1234, 32'hDEADBEEF, 32'h00000000},
        {1'b1, 8'd0, 16'h8001, 32'hFFFFFFFF, 32'hA5C3_0F96},
        {1'b0, 8'd1, 16'hFFFF, 32'h00000001, 32'h12345678},
        {1'b1, 8'd1, 16'h0000, 32'h00000000, 32'h8000_0001},
        {1'b0, 8'd1, 16'h0A0A, 32'h80000000, 32'h00000000},
        {1'b1, 8'd0, 16'h7FFE, 32'h13579BDF, 32'hFFFF_FFFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tgt_sel = '0;
    logic [15:0] reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_strobe = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic        idle;
    logic [7:0]  status;
    logic        sclk, mosi, miso;
    logic        cs_conv_n, cs_pll_n;

    always #2 clk = ~clk;

    spi_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .reg_addr(reg_addr),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .idle(idle), .status(status), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_conv_n(cs_conv_n), .cs_pll_n(cs_pll_n)
    );

    // peripheral model
    wire         cs_none = cs_conv_n & cs_pll_n;
    logic [48:0] cap = '0;
    int          bit_cnt = 0;
    int          frame_cnt = 0;
    logic        conv_seen = 1'b0, pll_seen = 1'b0;
    logic [31:0] slv_resp = '0;

    always @(posedge sclk or negedge cs_none) begin
        if (!sclk) begin
            frame_cnt <= frame_cnt + 1;
            bit_cnt   <= 0;
            cap       <= '0;
            conv_seen <= !cs_conv_n;
            pll_seen  <= !cs_pll_n;
        end else begin
            cap     <= {cap[47:0], mosi};
            bit_cnt <= bit_cnt + 1;
        end
    end

    always @(negedge sclk or negedge cs_none) begin
        if (!cs_none && bit_cnt >= 17 && bit_cnt <= 48)
            miso <= slv_resp[31 - (bit_cnt - 17)];
        else
            miso <= 1'b0;
    end

    int n_chk = 0, n_fail = 0;
    logic [31:0] last_rd = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && !idle; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        miso = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(idle == 1'b1 && cs_conv_n && cs_pll_n && !sclk, "R10 idle/cs/sclk", {idle, cs_conv_n, cs_pll_n, sclk}, 4'b1110);
        chk(rd_data == 0 && status == 0, "R10 rd_data/status", {rd_data, status}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic        is_rd;
            logic [7:0]  tg;
            logic [15:0] ad;
            logic [31:0] wd, rp;
            int          fc;
            {is_rd, tg, ad, wd, rp} = VEC[v];
            slv_resp = rp;
            tgt_sel = tg; reg_addr = ad; wr_data = wd;
            fc = frame_cnt;
            if (is_rd) rd_strobe = 1'b1; else wr_strobe = 1'b1;
            @(negedge clk);
            chk(idle == 1'b0, "R5 busy after edge", idle, 0);
            wait_idle();
            chk(cap == {is_rd, ad, (is_rd ? 32'h0 : wd)}, is_rd ? "R4 read frame" : "R3 write frame",
                cap, {is_rd, ad, (is_rd ? 32'h0 : wd)});
            chk(conv_seen == (tg == 0) && pll_seen == (tg == 1), "R1 chip select", {conv_seen, pll_seen}, {tg == 0, tg == 1});
            if (is_rd) last_rd = rp;
            chk(rd_data == last_rd, is_rd ? "R4 read data" : "R8 read data held", rd_data, last_rd);
            chk(status == 0, "R6 status ok", status, 0);
            repeat (40) @(negedge clk);
            chk(frame_cnt == fc + 1 && idle, "R3 held strobe no restart", frame_cnt, fc + 1);
            wr_strobe = 1'b0; rd_strobe = 1'b0;
            @(negedge clk);
        end

        // R6 undefined targets
        for (int t = 2; t < 4; t++) begin
            int fc;
            fc = frame_cnt;
            tgt_sel = (t == 2) ? 8'd2 : 8'd255;
            if (t == 2) wr_strobe = 1'b1; else rd_strobe = 1'b1;
            @(negedge clk);
            chk(idle == 1'b1 && status == 8'd3, "R6 undefined target", {idle, status}, {1'b1, 8'd3});
            repeat (30) @(negedge clk);
            chk(frame_cnt == fc && rd_data == last_rd, "R6 no frame / R8 hold", frame_cnt, fc);
            wr_strobe = 1'b0; rd_strobe = 1'b0;
            @(negedge clk);
        end

        // R7 edges and input changes during a frame
        begin
            int fc;
            fc = frame_cnt;
            tgt_sel = 8'd1; reg_addr = 16'hC0DE; wr_data = 32'h0BADF00D;
            wr_strobe = 1'b1;
            @(negedge clk);
            chk(status == 0, "R6 status back to ok", status, 0);
            repeat (20) @(negedge clk);
            rd_strobe = 1'b1; tgt_sel = 8'd0; reg_addr = 16'h1111; wr_data = 32'h22222222;
            wait_idle();
            chk(cap == {1'b0, 16'hC0DE, 32'h0BADF00D}, "R7 frame undisturbed", cap, {1'b0, 16'hC0DE, 32'h0BADF00D});
            chk(pll_seen && !conv_seen, "R7 target kept", {conv_seen, pll_seen}, 2'b01);
            repeat (20) @(negedge clk);
            chk(frame_cnt == fc + 1 && rd_data == last_rd, "R7 busy edge ignored", frame_cnt, fc + 1);
            wr_strobe = 1'b0; rd_strobe = 1'b0;
            @(negedge clk);
        end

        // R9 simultaneous strobes -> write
        tgt_sel = 8'd0; reg_addr = 16'h4242; wr_data = 32'hCAFE0001;
        wr_strobe = 1'b1; rd_strobe = 1'b1;
        @(negedge clk);
        wait_idle();
        chk(cap == {1'b0, 16'h4242, 32'hCAFE0001}, "R9 write wins", cap, {1'b0, 16'h4242, 32'hCAFE0001});
        chk(rd_data == last_rd, "R9 no read data change", rd_data, last_rd);
        wr_strobe = 1'b0; rd_strobe = 1'b0;
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule